// File: doc/BRIEF.md
# Multi-Lane Audio Transmit FIFO Bank

This block is the transmit store for a serial audio port with up to eight parallel data lanes. Each lane has a private FIFO. A configuration register holds a lane enable mask, and only enabled lanes take data and take part in draining. A bus-side write port loads the FIFOs in one of two ways. In per-lane mode, each lane has its own data address. In shared mode, one common address hands successive words to the enabled lanes in rising lane order and wraps back to the lowest one.

A bit-clock engine outside this block pulses `slot_strobe` once per frame slot. On each pulse, every enabled lane releases its oldest word into a registered output that the serializer reads. An enabled lane with nothing queued sends zero for that slot and latches a sticky underrun flag. A DMA request is raised while every enabled lane has drained to a programmable watermark or below.

A small control state machine has three states. IDLE means transmit is off and the FIFOs may be pre-filled. RUN means draining. FLUSH is a single cycle that empties every FIFO, resets the shared-mode rotation and zeroes the lane outputs. The transitions are:
- IDLE to RUN on a control write with the enable bit set.
- RUN to FLUSH on a control write with the enable bit clear.
- FLUSH to IDLE unconditionally.

Top module: `tx_lane_fifo_bank`

## Requirements
- R1: After reset the lane mask is 0x01, the word-flag field is 0, the combine field is 0, transmit is off, no underrun flag is set, all lane outputs are 0 and the DMA request is low.
- R2: A write to address 0 loads the configuration register. Bits 23:16 are the lane mask (bit 16+i enables lane i), bits 4:0 are the word-flag value, and bits 25:24 are the combine field. Shared mode is on when the combine field equals 2.
- R3: In per-lane mode, a write to address 8+i pushes the word into lane i's FIFO when lane i is enabled. In shared mode these addresses are ignored.
- R4: In shared mode, writes to address 16 go to the enabled lanes in ascending order and wrap to the lowest enabled lane. The first such write after reset or after a flush goes to the lowest enabled lane.
- R5: Disabled lanes ignore writes, never set an underrun flag and output 0.
- R6: On a `slot_strobe` while running, each enabled lane with queued data pops its oldest word. That word appears on its output after the next clock edge, in first-in first-out order. A push and a pop on the same lane in the same cycle both take effect.
- R7: On a `slot_strobe` while running, an enabled lane whose FIFO is empty outputs 0 for that slot and sets its sticky underrun flag.
- R8: Writing 1 to bit i of address 2 clears underrun flag i. If a clear and a new underrun hit the same lane in one cycle, the flag stays set.
- R9: `dma_req` is high while running and every enabled lane holds no more words than the watermark in bits 12:8 of address 1.
- R10: Bit 0 of address 1 turns transmit on. Clearing it while running passes through FLUSH, which discards all queued words, resets the rotation and zeroes the lane outputs.
- R11: Configuration writes made while running leave the mask, the word-flag value and the combine field unchanged.
- R12: Each FIFO holds 16 words. A 17th write to a full lane is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 5 | Bus word address |
| bus_wdata | input | 32 | Bus write data |
| slot_strobe | input | 1 | One pulse per frame slot from the bit-clock engine |
| lane_sd_word | output | 256 | Current slot word per lane, lane i at bits 32i+31:32i |
| underrun_flags | output | 8 | Sticky underrun flag per lane |
| dma_req | output | 1 | Refill request |
| lane_mask | output | 8 | Active lane enable mask |
| word_flag_cfg | output | 5 | Word-flag configuration value |
| combine_mode | output | 2 | Combine field, 2 selects shared address |
| tx_running | output | 1 | High in the RUN state |

## Verification
Two pairs of functions can land on the same cycle, and both are provoked on purpose.

The first pair is a slot drain and a bus write to the same lane. The bench writes one word to lane 0, then drives a second write together with `slot_strobe`. The lane must send the first word, raise no underrun, and send the second word on the following slot.

The second pair is a new underrun and its write-one-to-clear. The bench pulses `slot_strobe` on empty lanes while clearing one of their flags in the same cycle. It then checks that the flag stays set, and that a later clear alone removes it.

// File: rtl/txfb_pkg.sv
package txfb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2
    } tx_state_e;

    localparam int CFG_OFS    = 0;
    localparam int CTL_OFS    = 1;
    localparam int STS_OFS    = 2;
    localparam int LANE0_OFS  = 8;
    localparam int COMMON_OFS = 16;

    localparam logic [1:0] COMBINE_SHARED = 2'd2;
endpackage

// File: rtl/txfb_lane_fifo.sv
module txfb_lane_fifo #(
    parameter int W = 32,
    parameter int D = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   push,
    input  logic                   pop,
    input  logic [W-1:0]           din,
    output logic [W-1:0]           head,
    output logic [$clog2(D):0]     level,
    output logic                   full,
    output logic                   empty
);
    localparam int AW = $clog2(D);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [D];
    logic [AW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q;
    logic          push_ok, pop_ok;

    assign full    = cnt_q == CW'(D);
    assign empty   = cnt_q == '0;
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_q];
    assign level   = cnt_q;

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_q] <= din;
    end

    // D is a power of two, so the pointers wrap by overflow
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) wr_q <= wr_q + 1'b1;
            if (pop_ok)  rd_q <= rd_q + 1'b1;
            unique case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/txfb_rotor.sv
module txfb_rotor #(
    parameter int LANES = 8,
    parameter int LW    = 3
) (
    input  logic [LANES-1:0] lane_en,
    input  logic [LW-1:0]    start,
    output logic [LW-1:0]    pick,
    output logic             found
);
    int idx;

    // scan downward so the nearest enabled lane at or after start wins
    always_comb begin
        pick  = '0;
        found = 1'b0;
        idx   = 0;
        for (int i = LANES - 1; i >= 0; i--) begin
            idx = (int'(start) + i) % LANES;
            if (lane_en[idx]) begin
                pick  = LW'(idx);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tx_lane_fifo_bank.sv
module tx_lane_fifo_bank
    import txfb_pkg::*;
#(
    parameter int LANES      = 8,
    parameter int WORD_W     = 32,
    parameter int FIFO_DEPTH = 16,
    parameter int MASK_LSB   = 16,
    parameter int FLAG_W     = 5,
    parameter int ADDR_W     = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [31:0]             bus_wdata,
    input  logic                    slot_strobe,
    output logic [LANES*WORD_W-1:0] lane_sd_word,
    output logic [LANES-1:0]        underrun_flags,
    output logic                    dma_req,
    output logic [LANES-1:0]        lane_mask,
    output logic [FLAG_W-1:0]       word_flag_cfg,
    output logic [1:0]              combine_mode,
    output logic                    tx_running
);
    localparam int LW       = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int CW       = $clog2(FIFO_DEPTH) + 1;
    localparam int COMB_LSB = MASK_LSB + LANES;
    localparam int WM_LSB   = 8;
    localparam logic [ADDR_W-1:0] ADR_CFG    = ADDR_W'(CFG_OFS);
    localparam logic [ADDR_W-1:0] ADR_CTL    = ADDR_W'(CTL_OFS);
    localparam logic [ADDR_W-1:0] ADR_STS    = ADDR_W'(STS_OFS);
    localparam logic [ADDR_W-1:0] ADR_COMMON = ADDR_W'(COMMON_OFS);

    tx_state_e          state_q, state_d;
    logic [LANES-1:0]   mask_q;
    logic [FLAG_W-1:0]  wflag_q;
    logic [1:0]         comb_q;
    logic [CW-1:0]      wmark_q;
    logic [LW-1:0]      rot_q, rot_tgt, rot_next;
    logic               rot_hit;
    logic [LANES-1:0]   push, pop, full, empty, ur_q, ur_set;
    logic [WORD_W-1:0]  head [LANES];
    logic [CW-1:0]      level [LANES];
    logic [WORD_W-1:0]  sd_q [LANES];
    logic               running, flushing, shared;
    logic               wr_cfg, wr_ctl, wr_sts, wr_common, common_ok;
    logic               all_low;
    logic               unused_bits;

    assign running   = state_q == ST_RUN;
    assign flushing  = state_q == ST_FLUSH;
    assign shared    = comb_q == COMBINE_SHARED;
    assign wr_cfg    = bus_we && bus_addr == ADR_CFG;
    assign wr_ctl    = bus_we && bus_addr == ADR_CTL;
    assign wr_sts    = bus_we && bus_addr == ADR_STS;
    assign wr_common = bus_we && bus_addr == ADR_COMMON && shared && !flushing;
    assign common_ok = wr_common && rot_hit && !full[rot_tgt];
    assign unused_bits = ^bus_wdata;

    txfb_rotor #(.LANES(LANES), .LW(LW)) u_rotor (
        .lane_en (mask_q),
        .start   (rot_q),
        .pick    (rot_tgt),
        .found   (rot_hit)
    );

    always_comb rot_next = LW'((int'(rot_tgt) + 1) % LANES);

    // ---------------- per-lane datapath ----------------
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [ADDR_W-1:0] MY_ADR = ADDR_W'(LANE0_OFS + g);

        assign push[g] = mask_q[g] && !flushing &&
                         ((bus_we && !shared && bus_addr == MY_ADR) ||
                          (common_ok && rot_tgt == LW'(g)));
        assign pop[g]    = running && slot_strobe && mask_q[g] && !empty[g];
        assign ur_set[g] = running && slot_strobe && mask_q[g] && empty[g];

        txfb_lane_fifo #(.W(WORD_W), .D(FIFO_DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (flushing),
            .push  (push[g]),
            .pop   (pop[g]),
            .din   (bus_wdata[WORD_W-1:0]),
            .head  (head[g]),
            .level (level[g]),
            .full  (full[g]),
            .empty (empty[g])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        sd_q[g] <= '0;
            else if (flushing)                 sd_q[g] <= '0;
            else if (running && slot_strobe)   sd_q[g] <= pop[g] ? head[g] : '0;
        end

        assign lane_sd_word[g*WORD_W +: WORD_W] = sd_q[g];
    end

    // ---------------- control state machine ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (wr_ctl && bus_wdata[0])  state_d = ST_RUN;
            ST_RUN:   if (wr_ctl && !bus_wdata[0]) state_d = ST_FLUSH;
            ST_FLUSH: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // ---------------- registers driven by the state ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= LANES'(1);
            wflag_q <= '0;
            comb_q  <= '0;
            wmark_q <= '0;
            rot_q   <= '0;
            ur_q    <= '0;
        end else begin
            if (wr_cfg && !running) begin
                mask_q  <= bus_wdata[MASK_LSB +: LANES];
                wflag_q <= bus_wdata[FLAG_W-1:0];
                comb_q  <= bus_wdata[COMB_LSB +: 2];
            end
            if (wr_ctl) wmark_q <= bus_wdata[WM_LSB +: CW];
            if (flushing)       rot_q <= '0;
            else if (common_ok) rot_q <= rot_next;
            ur_q <= (ur_q & ~(wr_sts ? bus_wdata[LANES-1:0] : '0)) | ur_set;
        end
    end

    always_comb begin
        all_low = 1'b1;
        for (int i = 0; i < LANES; i++) begin
            if (mask_q[i] && level[i] > wmark_q) all_low = 1'b0;
        end
    end

    assign dma_req        = running && all_low;
    assign underrun_flags = ur_q;
    assign lane_mask      = mask_q;
    assign word_flag_cfg  = wflag_q;
    assign combine_mode   = comb_q;
    assign tx_running     = running;
endmodule

// File: rtl/txfb_checker.sv
module txfb_checker #(
    parameter int LANES  = 8,
    parameter int WORD_W = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    slot_strobe,
    input logic [LANES-1:0]        lane_mask,
    input logic [LANES-1:0]        underrun_flags,
    input logic [LANES*WORD_W-1:0] lane_sd_word,
    input logic                    tx_running
);
    // R5
    disabled_lane_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(underrun_flags & ~$past(underrun_flags) & ~$past(lane_mask))));

    // R7
    underrun_needs_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(underrun_flags & ~$past(underrun_flags))) |-> $past(slot_strobe));

    // R11
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tx_running) |-> $stable(lane_mask));

    // R10
    flush_zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_running) |=> (lane_sd_word == '0));

    // R6
    out_moves_on_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lane_sd_word) |-> ($past(slot_strobe) || ($past(tx_running, 2) && !$past(tx_running))));
endmodule

bind tx_lane_fifo_bank txfb_checker #(.LANES(LANES), .WORD_W(WORD_W)) u_txfb_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .slot_strobe    (slot_strobe),
    .lane_mask      (lane_mask),
    .underrun_flags (underrun_flags),
    .lane_sd_word   (lane_sd_word),
    .tx_running     (tx_running)
);

// File: tb/tx_lane_fifo_bank_test.sv
module tx_lane_fifo_bank_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_we = 1'b0;
    logic [4:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic         slot_strobe = 1'b0;
    logic [255:0] lane_sd_word;
    logic [7:0]   underrun_flags;
    logic         dma_req;
    logic [7:0]   lane_mask;
    logic [4:0]   word_flag_cfg;
    logic [1:0]   combine_mode;
    logic         tx_running;

    int checks = 0;
    int fails  = 0;
    int wd     = 0;

    always #10 clk = ~clk;   // 50 MHz

    tx_lane_fifo_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .slot_strobe(slot_strobe),
        .lane_sd_word(lane_sd_word), .underrun_flags(underrun_flags),
        .dma_req(dma_req), .lane_mask(lane_mask), .word_flag_cfg(word_flag_cfg),
        .combine_mode(combine_mode), .tx_running(tx_running)
    );

    // shared-mode walk: {destination lane, word}; lanes 2,5,7 enabled
    localparam logic [34:0] COMB_VEC [6] = '{
        {3'd2, 32'hC0DE_0000}, {3'd5, 32'hC0DE_0001}, {3'd7, 32'hC0DE_0002},
        {3'd2, 32'hC0DE_0003}, {3'd5, 32'hC0DE_0004}, {3'd7, 32'hC0DE_0005}
    };

    function automatic logic [31:0] sd(input int l);
        return lane_sd_word[l*32 +: 32];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic we, input logic [4:0] a, input logic [31:0] d, input logic stb);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d; slot_strobe = stb;
        @(negedge clk);
        bus_we = 1'b0; slot_strobe = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, 1'b0);
    endtask

    task automatic slot();
        cyc(1'b0, 5'd0, 32'd0, 1'b1);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd == 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<%0d", wd, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 mask", {24'd0, lane_mask}, 32'h01);
        chk("R1 wflag", {27'd0, word_flag_cfg}, 32'd0);
        chk("R1 combine", {30'd0, combine_mode}, 32'd0);
        chk("R1 running", {31'd0, tx_running}, 32'd0);
        chk("R1 underrun", {24'd0, underrun_flags}, 32'd0);
        chk("R1 dma", {31'd0, dma_req}, 32'd0);
        chk("R1 out", {31'd0, |lane_sd_word}, 32'd0);

        // R2 configuration fields: lanes 0,1, flag 5, per-lane mode
        wr(5'd0, (32'h03 << 16) | 32'd5);
        chk("R2 mask", {24'd0, lane_mask}, 32'h03);
        chk("R2 wflag", {27'd0, word_flag_cfg}, 32'd5);
        chk("R2 combine", {30'd0, combine_mode}, 32'd0);

        // R3 per-lane loads; R5 write to disabled lane 3
        wr(5'd8,  32'hA000_0000);
        wr(5'd8,  32'hA000_0001);
        wr(5'd9,  32'hB000_0000);
        wr(5'd11, 32'hCCCC_0000);
        wr(5'd1,  32'h0000_0101);   // run, watermark 1
        chk("R10 running", {31'd0, tx_running}, 32'd1);
        chk("R9 dma above mark", {31'd0, dma_req}, 32'd0);

        slot();
        chk("R6 lane0 first", sd(0), 32'hA000_0000);
        chk("R3 lane1", sd(1), 32'hB000_0000);
        chk("R5 lane3 zero", sd(3), 32'd0);
        chk("R9 dma at mark", {31'd0, dma_req}, 32'd1);

        // R11 config write while running
        wr(5'd0, 32'h00FF_0000);
        chk("R11 mask frozen", {24'd0, lane_mask}, 32'h03);

        slot();
        chk("R6 lane0 second", sd(0), 32'hA000_0001);
        chk("R7 lane1 zero", sd(1), 32'd0);
        chk("R7 flags", {24'd0, underrun_flags}, 32'h02);

        // R8 clear colliding with a new underrun on both lanes
        cyc(1'b1, 5'd2, 32'h02, 1'b1);
        chk("R8 set wins", {24'd0, underrun_flags}, 32'h03);
        wr(5'd2, 32'h03);
        chk("R8 cleared", {24'd0, underrun_flags}, 32'h00);

        // R6 push and pop on lane 0 in the same cycle
        wr(5'd8, 32'hE000_0000);
        cyc(1'b1, 5'd8, 32'hE000_0001, 1'b1);
        chk("R6 collide out", sd(0), 32'hE000_0000);
        chk("R6 collide flag", {31'd0, underrun_flags[0]}, 32'd0);
        slot();
        chk("R6 collide next", sd(0), 32'hE000_0001);
        wr(5'd2, 32'hFF);

        // R10 flush discards queued words
        wr(5'd8, 32'hF000_0000);
        wr(5'd1, 32'h0000_0100);
        chk("R10 stopped", {31'd0, tx_running}, 32'd0);
        @(negedge clk);
        chk("R10 out zero", {31'd0, |lane_sd_word}, 32'd0);
        wr(5'd1, 32'h0000_0101);
        slot();
        chk("R10 flushed", sd(0), 32'd0);
        chk("R10 flushed flag", {31'd0, underrun_flags[0]}, 32'd1);
        wr(5'd2, 32'hFF);

        // R4 shared mode walk
        wr(5'd1, 32'd0);
        @(negedge clk);
        wr(5'd0, (32'd2 << 24) | (32'hA4 << 16));
        chk("R2 shared", {30'd0, combine_mode}, 32'd2);
        chk("R2 mask A4", {24'd0, lane_mask}, 32'hA4);
        wr(5'd10, 32'hDEAD_0000);   // R3 ignored in shared mode
        for (int k = 0; k < 6; k++) wr(5'd16, COMB_VEC[k][31:0]);
        wr(5'd1, 32'h0000_0101);
        for (int s = 0; s < 2; s++) begin
            slot();
            for (int k = s * 3; k < s * 3 + 3; k++)
                chk("R4 rotation", sd(int'(COMB_VEC[k][34:32])), COMB_VEC[k][31:0]);
        end
        slot();
        chk("R3 shared ignores lane addr", sd(2), 32'd0);
        chk("R5 flags only enabled", {24'd0, underrun_flags}, 32'hA4);
        wr(5'd2, 32'hFF);

        // R4 rotation restarts at lowest lane after a flush
        wr(5'd1, 32'd0);
        @(negedge clk);
        wr(5'd16, 32'h5000_0000);
        wr(5'd1, 32'h0000_0001);
        wr(5'd1, 32'd0);
        @(negedge clk);
        wr(5'd16, 32'h5000_0001);
        wr(5'd1, 32'h0000_0001);
        slot();
        chk("R4 restart lane2", sd(2), 32'h5000_0001);
        chk("R4 restart lane5", sd(5), 32'd0);
        wr(5'd2, 32'hFF);

        // R12 depth 16: 17th write dropped
        wr(5'd1, 32'd0);
        @(negedge clk);
        wr(5'd0, 32'h01 << 16);
        for (int k = 0; k < 17; k++) wr(5'd8, 32'h100 + k);
        wr(5'd1, 32'h0000_0F01);
        chk("R9 sixteen over 15", {31'd0, dma_req}, 32'd0);
        wr(5'd1, 32'h0000_1001);
        chk("R9 sixteen at 16", {31'd0, dma_req}, 32'd1);
        for (int k = 0; k < 16; k++) begin
            slot();
            chk("R12 drain", sd(0), 32'h100 + k);
        end
        slot();
        chk("R12 dropped", sd(0), 32'd0);
        chk("R12 underrun", {31'd0, underrun_flags[0]}, 32'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule